// File: doc/BRIEF.md
# Card Host Bus Byte-Lane Decoder

This block sits behind the host pins of a removable storage card. It watches the active-low card enables, the attribute-space select, the three low address bits and the four host strobes (output enable, write enable, I/O read, I/O write). From these it works out which kind of register access the host is making and how the two data byte lanes must be steered. A static mode input chooses between memory-mapped operation, I/O-mapped operation and a disk-style mode in which the two card enables act as chip selects for a task-file block and a control block.

All host pins are asynchronous to the card controller. Each pin passes through a two-stage synchronizer into the system clock domain. The decoder then produces one read strobe pulse on the leading edge of each qualifying read, and one write strobe pulse on the trailing edge of each qualifying write. Alongside each pulse it gives an access description: the space, the register index, the width class and a byte-swap flag. While a read is held it also drives level enables for the low lane (D0-D7) and the high lane (D8-D15). Register contents and pad drivers belong to neighbouring blocks.

Top module: `cfl_lane_decoder`

## Requirements
- R1: In memory and I/O modes, when both card enables are high (standby), no strobe is produced and both lane enables stay low, whichever host strobe toggles.
- R2: When both card enables are low, an access reports width code 2 (word). A read enables both lanes. The swap flag is 0.
- R3: With the low-byte enable low and the high-byte enable high, an access reports width code 1 (byte) and a read enables only the low lane. The swap flag equals address bit 0, so the odd byte is steered onto the low lane when A0 is 1.
- R4: With the high-byte enable low and the low-byte enable high, an access reports width code 3 (odd-only) and a read enables only the high lane.
- R5: When the attribute select is low (memory or I/O mode), the space code is 1 and the high lane is never enabled. An access that could carry only an odd byte (odd-only, or byte at an odd address) produces no strobe. Other accesses report space code 2 (task file/common) with the index taken from the address.
- R6: Mode code 0 (memory) qualifies reads and writes with the output-enable and write-enable pins. Mode 1 (I/O) does the same for attribute space but uses the I/O read and I/O write pins for task-file space. Mode 2 (disk-style) uses the I/O pins only. Mode 3 never produces an access. The strobes of the other family have no effect.
- R7: In mode 2, the low-byte enable low with the high-byte enable high selects the task file (space 2, index = address). Index 0 is word wide on both lanes, unless the 8-bit input is high, in which case it is byte wide on the low lane. Indices 1 to 7 are byte wide on the low lane.
- R8: In mode 2, the high-byte enable low with the low-byte enable high and address 6 selects the control block (space 3, byte, low lane). Any other address with that select pattern, and both enables low together, produce no access. The select pin levels have no effect in this mode.
- R9: Each qualifying read produces exactly one read strobe pulse, starting after the read pin falls. The lane enables stay on while the read is held and drop after it ends.
- R10: Each qualifying write produces exactly one write strobe pulse, and only after the write pin rises again. That pulse carries the description of the access decoded while the write was held.
- R11: After reset, both strobes, both lane enables, the swap flag and all description fields are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | 0 memory, 1 I/O, 2 disk-style, 3 off |
| ide_8bit | input | 1 | Forces the disk-style data register to byte width |
| reg_n | input | 1 | Attribute-space select, active low |
| ce1_n | input | 1 | Low-byte card enable, active low |
| ce2_n | input | 1 | High-byte card enable, active low |
| addr | input | 3 | Host address bits 2..0 |
| oe_n | input | 1 | Memory read strobe, active low |
| we_n | input | 1 | Memory write strobe, active low |
| iord_n | input | 1 | I/O read strobe, active low |
| iowr_n | input | 1 | I/O write strobe, active low |
| rd_stb | output | 1 | One-cycle read access pulse |
| wr_stb | output | 1 | One-cycle write access pulse |
| acc_space | output | 2 | 0 none, 1 attribute, 2 task file/common, 3 control block |
| acc_idx | output | 3 | Register index of the access |
| acc_width | output | 2 | 0 none, 1 byte, 2 word, 3 odd-only |
| acc_swap | output | 1 | Route the odd byte onto the low lane |
| lo_oe | output | 1 | Drive enable for D0-D7 |
| hi_oe | output | 1 | Drive enable for D8-D15 |

## Verification
The assertions assume the host never holds a read pin and a write pin active at the same time. They also assume every pin stays steady for more than two clock cycles around each strobe edge, so that the synchronized copies of enables, address and strobes move together. The stimulus sets the selects, address and mode first. It waits four cycles, holds a single strobe for six cycles, and releases it for six more before anything else changes. Every combination of mode, attribute select, enable pair, address, 8-bit setting and strobe family is swept this way.

// File: rtl/cfl_pkg.sv
package cfl_pkg;

  localparam int unsigned TF_ADDR_W = 3;

  typedef enum logic [1:0] {
    MODE_MEM = 2'd0,
    MODE_IO  = 2'd1,
    MODE_IDE = 2'd2,
    MODE_OFF = 2'd3
  } bus_mode_e;

  typedef enum logic [1:0] {
    SPC_NONE = 2'd0,
    SPC_ATTR = 2'd1,
    SPC_TASK = 2'd2,
    SPC_CTRL = 2'd3
  } space_e;

  typedef enum logic [1:0] {
    WID_NONE = 2'd0,
    WID_BYTE = 2'd1,
    WID_WORD = 2'd2,
    WID_ODD  = 2'd3
  } width_e;

  // host pins after synchronization
  typedef struct packed {
    logic                 reg_n;
    logic                 ce1_n;
    logic                 ce2_n;
    logic [TF_ADDR_W-1:0] addr;
    logic                 oe_n;
    logic                 we_n;
    logic                 iord_n;
    logic                 iowr_n;
    logic [1:0]           mode;
    logic                 ide8;
  } pins_t;

  localparam int unsigned PINS_W = $bits(pins_t);

  // access description reported with each strobe
  typedef struct packed {
    space_e               space;
    logic [TF_ADDR_W-1:0] idx;
    width_e               width;
    logic                 swap;
  } acc_t;

  typedef struct packed {
    acc_t acc;
    logic lo;
    logic hi;
    logic rd;
    logic wr;
  } decode_t;

endpackage

// File: rtl/cfl_rst_sync.sv
module cfl_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/cfl_sync.sv
module cfl_sync #(
  parameter int unsigned       W       = 1,
  parameter int unsigned       STAGES  = 2,
  parameter logic [W-1:0]      RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [W-1:0] stage_d;
    if (g == 0) begin : g_first
      assign stage_d = d;
    end else begin : g_next
      assign stage_d = stage_q[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[g] <= RST_VAL;
      else        stage_q[g] <= stage_d;
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/cfl_decode.sv
module cfl_decode
  import cfl_pkg::*;
#(
  parameter int unsigned CTRL_IDX = 6,
  parameter int unsigned DATA_IDX = 0
) (
  input  pins_t   p,
  output decode_t d
);
  localparam logic [TF_ADDR_W-1:0] CTRL_A = TF_ADDR_W'(CTRL_IDX);
  localparam logic [TF_ADDR_W-1:0] DATA_A = TF_ADDR_W'(DATA_IDX);

  logic hit;
  logic rd_raw;
  logic wr_raw;

  always_comb begin
    hit          = 1'b0;
    rd_raw       = 1'b0;
    wr_raw       = 1'b0;
    d.acc.space  = SPC_NONE;
    d.acc.idx    = p.addr;
    d.acc.width  = WID_NONE;
    d.acc.swap   = 1'b0;
    d.lo         = 1'b0;
    d.hi         = 1'b0;

    unique case (bus_mode_e'(p.mode))
      MODE_IDE: begin
        rd_raw = !p.iord_n;
        wr_raw = !p.iowr_n;
        if (!p.ce1_n && p.ce2_n) begin
          hit         = 1'b1;
          d.acc.space = SPC_TASK;
          d.lo        = 1'b1;
          if (p.addr == DATA_A && !p.ide8) begin
            d.acc.width = WID_WORD;
            d.hi        = 1'b1;
          end else begin
            d.acc.width = WID_BYTE;
          end
        end else if (p.ce1_n && !p.ce2_n && p.addr == CTRL_A) begin
          hit         = 1'b1;
          d.acc.space = SPC_CTRL;
          d.acc.width = WID_BYTE;
          d.lo        = 1'b1;
        end
      end
      MODE_MEM, MODE_IO: begin
        if (!p.reg_n || bus_mode_e'(p.mode) == MODE_MEM) begin
          rd_raw = !p.oe_n;
          wr_raw = !p.we_n;
        end else begin
          rd_raw = !p.iord_n;
          wr_raw = !p.iowr_n;
        end
        unique case ({p.ce2_n, p.ce1_n})
          2'b00: begin
            hit         = 1'b1;
            d.acc.width = WID_WORD;
            d.lo        = 1'b1;
            d.hi        = 1'b1;
          end
          2'b10: begin
            hit         = 1'b1;
            d.acc.width = WID_BYTE;
            d.acc.swap  = p.addr[0];
            d.lo        = 1'b1;
          end
          2'b01: begin
            hit         = 1'b1;
            d.acc.width = WID_ODD;
            d.hi        = 1'b1;
          end
          default: hit = 1'b0;
        endcase
        d.acc.space = hit ? SPC_TASK : SPC_NONE;
        if (!p.reg_n) begin
          // attribute space carries even bytes only
          if (d.acc.width == WID_ODD || d.acc.swap) begin
            hit = 1'b0;
          end
          d.acc.space = hit ? SPC_ATTR : SPC_NONE;
          d.hi        = 1'b0;
        end
      end
      default: hit = 1'b0;
    endcase

    d.rd = hit && rd_raw;
    d.wr = hit && wr_raw;
  end
endmodule

// File: rtl/cfl_lane_decoder.sv
module cfl_lane_decoder
  import cfl_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned CTRL_IDX    = 6,
  parameter int unsigned DATA_IDX    = 0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           mode,
  input  logic                 ide_8bit,
  input  logic                 reg_n,
  input  logic                 ce1_n,
  input  logic                 ce2_n,
  input  logic [TF_ADDR_W-1:0] addr,
  input  logic                 oe_n,
  input  logic                 we_n,
  input  logic                 iord_n,
  input  logic                 iowr_n,
  output logic                 rd_stb,
  output logic                 wr_stb,
  output logic [1:0]           acc_space,
  output logic [TF_ADDR_W-1:0] acc_idx,
  output logic [1:0]           acc_width,
  output logic                 acc_swap,
  output logic                 lo_oe,
  output logic                 hi_oe
);
  localparam pins_t PINS_IDLE = '{
    reg_n: 1'b1, ce1_n: 1'b1, ce2_n: 1'b1, addr: '0,
    oe_n: 1'b1, we_n: 1'b1, iord_n: 1'b1, iowr_n: 1'b1,
    mode: 2'(MODE_OFF), ide8: 1'b0
  };
  localparam acc_t ACC_IDLE = '{space: SPC_NONE, idx: '0, width: WID_NONE, swap: 1'b0};

  logic    rst_n_int;
  pins_t   pins_raw;
  pins_t   pins_s;
  decode_t dec;

  cfl_rst_sync #(.STAGES(SYNC_STAGES)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  assign pins_raw = '{
    reg_n: reg_n, ce1_n: ce1_n, ce2_n: ce2_n, addr: addr,
    oe_n: oe_n, we_n: we_n, iord_n: iord_n, iowr_n: iowr_n,
    mode: mode, ide8: ide_8bit
  };

  cfl_sync #(.W(PINS_W), .STAGES(SYNC_STAGES), .RST_VAL(PINS_IDLE)) i_pin_sync (
    .clk   (clk),
    .rst_n (rst_n_int),
    .d     (pins_raw),
    .q     (pins_s)
  );

  cfl_decode #(.CTRL_IDX(CTRL_IDX), .DATA_IDX(DATA_IDX)) i_decode (
    .p (pins_s),
    .d (dec)
  );

  // state
  logic rd_prev_q, rd_prev_d;
  logic wr_prev_q, wr_prev_d;
  acc_t wr_hold_q, wr_hold_d;
  acc_t acc_q,     acc_d;
  logic rd_stb_q,  rd_stb_d;
  logic wr_stb_q,  wr_stb_d;
  logic lo_q,      lo_d;
  logic hi_q,      hi_d;
  logic rd_evt, wr_evt;
  logic hold_en, acc_en;

  // next state
  always_comb begin
    rd_evt    = dec.rd && !rd_prev_q;
    wr_evt    = !dec.wr && wr_prev_q;
    rd_prev_d = dec.rd;
    wr_prev_d = dec.wr;
    hold_en   = dec.wr;
    wr_hold_d = hold_en ? dec.acc : wr_hold_q;
    acc_en    = rd_evt || wr_evt;
    acc_d     = acc_q;
    if (rd_evt)      acc_d = dec.acc;
    else if (wr_evt) acc_d = wr_hold_q;
    rd_stb_d  = rd_evt;
    wr_stb_d  = wr_evt && !rd_evt;
    lo_d      = dec.rd && dec.lo;
    hi_d      = dec.rd && dec.hi;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      rd_prev_q <= 1'b0;
      wr_prev_q <= 1'b0;
      wr_hold_q <= ACC_IDLE;
      acc_q     <= ACC_IDLE;
      rd_stb_q  <= 1'b0;
      wr_stb_q  <= 1'b0;
      lo_q      <= 1'b0;
      hi_q      <= 1'b0;
    end else begin
      rd_prev_q <= rd_prev_d;
      wr_prev_q <= wr_prev_d;
      if (hold_en) wr_hold_q <= wr_hold_d;
      if (acc_en)  acc_q     <= acc_d;
      rd_stb_q  <= rd_stb_d;
      wr_stb_q  <= wr_stb_d;
      lo_q      <= lo_d;
      hi_q      <= hi_d;
    end
  end

  assign rd_stb    = rd_stb_q;
  assign wr_stb    = wr_stb_q;
  assign acc_space = 2'(acc_q.space);
  assign acc_idx   = acc_q.idx;
  assign acc_width = 2'(acc_q.width);
  assign acc_swap  = acc_q.swap;
  assign lo_oe     = lo_q;
  assign hi_oe     = hi_q;
endmodule

// File: rtl/cfl_lane_decoder_chk.sv
module cfl_lane_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_stb,
  input logic       wr_stb,
  input logic [1:0] acc_space,
  input logic [1:0] acc_width,
  input logic       acc_swap,
  input logic       lo_oe,
  input logic       hi_oe
);
  assert_rd_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> !rd_stb);

  assert_wr_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);

  assert_one_kind_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_stb, wr_stb}));

  assert_attr_no_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && acc_space == 2'd1) |-> !hi_oe);

  assert_word_no_swap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_stb || wr_stb) && acc_width == 2'd2) |-> !acc_swap);

  assert_odd_high_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && acc_width == 2'd3) |-> (hi_oe && !lo_oe));

  assert_ctrl_byte_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_stb || wr_stb) && acc_space == 2'd3) |-> (acc_width == 2'd1));

  assert_read_lanes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && acc_width != 2'd0) |-> (lo_oe || hi_oe));
endmodule

bind cfl_lane_decoder cfl_lane_decoder_chk i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rd_stb    (rd_stb),
  .wr_stb    (wr_stb),
  .acc_space (acc_space),
  .acc_width (acc_width),
  .acc_swap  (acc_swap),
  .lo_oe     (lo_oe),
  .hi_oe     (hi_oe)
);

// File: tb/test_cfl_lane_decoder.sv
module test_cfl_lane_decoder;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'd3;
  logic       ide_8bit = 1'b0;
  logic       reg_n = 1'b1, ce1_n = 1'b1, ce2_n = 1'b1;
  logic [2:0] addr = 3'd0;
  logic       oe_n = 1'b1, we_n = 1'b1, iord_n = 1'b1, iowr_n = 1'b1;
  logic       rd_stb, wr_stb, acc_swap, lo_oe, hi_oe;
  logic [1:0] acc_space, acc_width;
  logic [2:0] acc_idx;

  int checks = 0;
  int errors = 0;
  int rd_cnt = 0;
  int wr_cnt = 0;
  int last_sp, last_ix, last_wd, last_sw;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cfl_lane_decoder i_cfl_lane_decoder (
    .clk(clk), .rst_n(rst_n), .mode(mode), .ide_8bit(ide_8bit),
    .reg_n(reg_n), .ce1_n(ce1_n), .ce2_n(ce2_n), .addr(addr),
    .oe_n(oe_n), .we_n(we_n), .iord_n(iord_n), .iowr_n(iowr_n),
    .rd_stb(rd_stb), .wr_stb(wr_stb), .acc_space(acc_space), .acc_idx(acc_idx),
    .acc_width(acc_width), .acc_swap(acc_swap), .lo_oe(lo_oe), .hi_oe(hi_oe)
  );

  // pulse monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (rd_stb || wr_stb) begin
      last_sp = int'(acc_space);
      last_ix = int'(acc_idx);
      last_wd = int'(acc_width);
      last_sw = int'(acc_swap);
    end
    if (rd_stb) rd_cnt++;
    if (wr_stb) wr_cnt++;
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // requirement model: hit, space, index, width, swap, low lane, high lane
  task automatic model(input int m, rg, c1, c2, a, b8,
                       output int hit, sp, ix, wd, sw, lo, hi, output string tag);
    hit = 0; sp = 0; ix = a; wd = 0; sw = 0; lo = 0; hi = 0; tag = "R6";
    if (m == 2) begin
      tag = "R8";
      if (c1 == 0 && c2 == 1) begin
        tag = "R7"; hit = 1; sp = 2; lo = 1;
        if (a == 0 && b8 == 0) begin wd = 2; hi = 1; end else wd = 1;
      end else if (c1 == 1 && c2 == 0 && a == 6) begin
        hit = 1; sp = 3; wd = 1; lo = 1;
      end
    end else if (m < 2) begin
      if (c1 == 1 && c2 == 1) tag = "R1";
      else if (c1 == 0 && c2 == 0) begin tag = "R2"; hit = 1; wd = 2; lo = 1; hi = 1; end
      else if (c1 == 0) begin tag = "R3"; hit = 1; wd = 1; lo = 1; sw = a % 2; end
      else begin tag = "R4"; hit = 1; wd = 3; hi = 1; end
      if (hit == 1) sp = 2;
      if (rg == 0) begin
        tag = "R5"; hi = 0;
        if (wd == 3 || sw == 1) begin hit = 0; sp = 0; end else sp = 1;
      end
    end
  endtask

  // kind: 0 read, 1 write; fam 0 memory pins, 1 I/O pins
  task automatic drive(input int kind, input int fam, input logic lvl);
    if (kind == 0) begin
      if (fam == 0) oe_n = lvl; else iord_n = lvl;
    end else begin
      if (fam == 0) we_n = lvl; else iowr_n = lvl;
    end
  endtask

  task automatic run_op(input int m, rg, c1, c2, a, b8, kind, wrong);
    int hit, sp, ix, wd, sw, lo, hi, fam, acc;
    string tag;
    model(m, rg, c1, c2, a, b8, hit, sp, ix, wd, sw, lo, hi, tag);
    fam = (m == 2) ? 1 : ((m == 1 && rg == 1) ? 1 : 0);
    if (wrong != 0) fam = 1 - fam;
    acc = (hit == 1 && wrong == 0) ? 1 : 0;
    if (wrong != 0) tag = "R6";
    @(negedge clk);
    mode = 2'(m); reg_n = 1'(rg); ce1_n = 1'(c1); ce2_n = 1'(c2);
    addr = 3'(a); ide_8bit = 1'(b8);
    repeat (4) @(negedge clk);
    rd_cnt = 0; wr_cnt = 0;
    drive(kind, fam, 1'b0);
    repeat (6) @(negedge clk);
    if (kind == 0) begin
      chk("R9", "read pulses while held", rd_cnt, acc);
      chk(tag, "low lane", int'(lo_oe), acc * lo);
      chk(tag, "high lane", int'(hi_oe), acc * hi);
    end else begin
      chk("R10", "write pulses before release", wr_cnt, 0);
    end
    drive(kind, fam, 1'b1);
    repeat (6) @(negedge clk);
    chk(kind == 0 ? "R9" : "R10", "pulses after release", rd_cnt + wr_cnt, acc);
    chk("R9", "lanes off after release", int'(lo_oe) + int'(hi_oe), 0);
    if (acc == 1) begin
      chk(tag, "space", last_sp, sp);
      chk(tag, "index", last_ix, ix);
      chk(tag, "width", last_wd, wd);
      chk(tag, "swap", last_sw, sw);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R11", "reset strobes", int'(rd_stb) + int'(wr_stb), 0);
    chk("R11", "reset lanes", int'(lo_oe) + int'(hi_oe), 0);
    chk("R11", "reset description",
        int'(acc_space) + int'(acc_idx) + int'(acc_width) + int'(acc_swap), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R11", "idle after release", int'(rd_stb) + int'(wr_stb) + int'(lo_oe), 0);
    for (int m = 0; m < 4; m++)
      for (int rg = 0; rg < 2; rg++)
        for (int ce = 0; ce < 4; ce++)
          for (int a = 0; a < 8; a++)
            for (int b8 = 0; b8 < ((m == 2) ? 2 : 1); b8++)
              for (int k = 0; k < 4; k++)
                run_op(m, rg, ce % 2, ce / 2, a, b8, k % 2, k / 2);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule